// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Unit

This block holds the machine-level trap state of a small RISC-V style core. When the core has a decoded exception for the instruction at `pc_i`, the block records the faulting PC, the cause code and the trap value. It also saves the interrupt-enable bit and the current privilege into the status fields, moves to Machine privilege and redirects fetch to the trap base. On a machine-mode return it restores the enable bit and the privilege from the saved fields and redirects fetch to the saved PC.

Environment calls are requested with any of the three call codes. The block substitutes the cause that matches the privilege at the time of the call. A retiring 16-bit instruction raises an illegal-instruction trap by itself whenever the compressed-extension bit is clear. Requests that cannot be served produce a one-cycle internal-error pulse and change no state. These are reserved codes, breakpoints, missing trap values and a return to an unsupported saved privilege. All state and all outputs are registered and update together on one clock edge.

Top module: `mtrap_unit`

## Requirements
- R1: After a synchronous active-high reset, the unit holds these values: privilege Machine (11), compressed bit 1, enable bit 0, saved enable 0, saved privilege 00, saved PC, cause and trap value all 0, and redirect and error low.
- R2: A served trap updates state at the next clock edge. The saved PC becomes `pc_i`, the cause becomes the 4-bit code zero-extended to XLEN, `redirect_o` pulses for one cycle, and `next_pc_o` becomes `mtvec_i` with its low two bits cleared.
- R3: On a served trap the saved enable takes the old enable, the enable clears, the saved privilege takes the old privilege, and the privilege becomes Machine. The privilege encodings are User 00, Supervisor 01 and Machine 11.
- R4: Trap codes 8, 9 and 11 all request an environment call. The recorded cause is 8 from User, 9 from Supervisor and 11 from Machine, and the trap value is written with 0.
- R5: For codes 0, 1, 2, 4, 5, 6, 7, 12, 13 and 15, the trap value takes `tval_i` when `tval_valid_i` is high.
- R6: A trap with one of the R5 codes and `tval_valid_i` low pulses `err_o` for one cycle. It leaves every state output unchanged and gives no redirect.
- R7: Trap codes 3, 10 and 14 pulse `err_o`, change no state and give no redirect.
- R8: When `cchk_i` is high and the compressed bit is 0, the unit serves an illegal-instruction trap with cause 2. The trap value is `cbits_i` zero-extended. When the compressed bit is 1, `cchk_i` has no effect.
- R9: `cext_we_i` loads `cext_d_i` into the compressed bit at the next edge. A check in the same cycle uses the old value.
- R10: MRET sets the enable to the saved enable, sets the saved enable to 1, sets the privilege to the saved privilege and sets the saved privilege to 00. It pulses `redirect_o`, and `next_pc_o` becomes the old saved PC.
- R11: Priority order is `trap_req_i` first, then the compressed check, then `mret_req_i`. A lower-priority request in the same cycle is ignored.
- R12: `mpp_we_i` loads `mpp_d_i` into the saved privilege only when no trap attempt and no MRET is present. An MRET with saved privilege 10 pulses `err_o` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | XLEN | PC of the current instruction |
| mtvec_i | input | XLEN | Trap base, direct mode |
| trap_req_i | input | 1 | Decoded exception request |
| trap_code_i | input | 4 | Exception code of the request |
| tval_valid_i | input | 1 | `tval_i` is supplied |
| tval_i | input | XLEN | Trap value |
| cchk_i | input | 1 | A 16-bit instruction is retiring |
| cbits_i | input | 16 | Bits of that instruction |
| mret_req_i | input | 1 | Machine return request |
| cext_we_i | input | 1 | Compressed-bit write enable |
| cext_d_i | input | 1 | Compressed-bit write value |
| mpp_we_i | input | 1 | Saved-privilege write enable |
| mpp_d_i | input | 2 | Saved-privilege write value |
| redirect_o | output | 1 | Next-PC valid pulse |
| next_pc_o | output | XLEN | Redirect target |
| mepc_o | output | XLEN | Saved PC |
| mcause_o | output | XLEN | Trap cause |
| mtval_o | output | XLEN | Trap value |
| mie_o | output | 1 | Interrupt enable |
| mpie_o | output | 1 | Saved interrupt enable |
| mpp_o | output | 2 | Saved privilege |
| priv_o | output | 2 | Current privilege |
| cext_o | output | 1 | Compressed-extension bit |
| err_o | output | 1 | Internal-error pulse |

## Verification
Every state field is itself an output, so a wrong update is visible one cycle after the edge that caused it. Some faults stay hidden until a later request. A wrong saved privilege or saved enable shows up only at the next MRET, as a wrong privilege or enable. A wrong saved PC shows up as a wrong return target. A wrong privilege shows up as a wrong environment-call cause at the next call. The bench therefore chains traps, writes and returns so that each saved field is consumed later.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [1:0] PRIV_RSV = 2'b10;

  localparam logic [3:0] EC_ILLEGAL = 4'd2;
  localparam logic [3:0] EC_UCALL   = 4'd8;
  localparam logic [3:0] EC_SCALL   = 4'd9;
  localparam logic [3:0] EC_MCALL   = 4'd11;

  // how the trap value is formed for a code
  typedef enum logic [1:0] {TV_GIVEN, TV_ZERO, TV_REFUSE} tval_rule_e;

  function automatic tval_rule_e rule_of(input logic [3:0] code);
    case (code)
      4'd8, 4'd9, 4'd11:  rule_of = TV_ZERO;
      4'd3, 4'd10, 4'd14: rule_of = TV_REFUSE;
      default:            rule_of = TV_GIVEN;
    endcase
  endfunction
endpackage

// File: rtl/mtrap_cause.sv
module mtrap_cause
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CLEN = 16
) (
  input  logic [1:0]      priv_i,
  input  logic            trap_req_i,
  input  logic [3:0]      code_i,
  input  logic            tval_valid_i,
  input  logic [XLEN-1:0] tval_i,
  input  logic            cchk_i,
  input  logic [CLEN-1:0] cbits_i,
  input  logic            cext_i,
  output logic            attempt_o,
  output logic            take_o,
  output logic            bad_o,
  output logic [3:0]      cause_o,
  output logic [XLEN-1:0] tval_o
);
  logic c_illegal;
  assign c_illegal = cchk_i && !cext_i;
  assign attempt_o = trap_req_i || c_illegal;

  always_comb begin
    take_o  = 1'b0;
    bad_o   = 1'b0;
    cause_o = code_i;
    tval_o  = '0;
    if (trap_req_i) begin
      case (rule_of(code_i))
        TV_ZERO: begin
          take_o = 1'b1;
          case (priv_i)
            PRIV_U:  cause_o = EC_UCALL;
            PRIV_S:  cause_o = EC_SCALL;
            default: cause_o = EC_MCALL;
          endcase
        end
        TV_GIVEN: begin
          if (tval_valid_i) begin
            take_o = 1'b1;
            tval_o = tval_i;
          end else begin
            bad_o = 1'b1;
          end
        end
        default: bad_o = 1'b1;
      endcase
    end else if (c_illegal) begin
      take_o  = 1'b1;
      cause_o = EC_ILLEGAL;
      tval_o  = XLEN'(cbits_i);
    end
  end
endmodule

// File: rtl/mtrap_status.sv
module mtrap_status
  import mtrap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       take_i,
  input  logic       ret_i,
  input  logic       mpp_wr_i,
  input  logic [1:0] mpp_d_i,
  input  logic       cext_we_i,
  input  logic       cext_d_i,
  output logic       mie_o,
  output logic       mpie_o,
  output logic [1:0] mpp_o,
  output logic [1:0] priv_o,
  output logic       cext_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mie_o  <= 1'b0;
      mpie_o <= 1'b0;
      mpp_o  <= PRIV_U;
      priv_o <= PRIV_M;
      cext_o <= 1'b1;
    end else begin
      if (take_i) begin
        mpie_o <= mie_o;
        mie_o  <= 1'b0;
        mpp_o  <= priv_o;
        priv_o <= PRIV_M;
      end else if (ret_i) begin
        mie_o  <= mpie_o;
        mpie_o <= 1'b1;
        priv_o <= mpp_o;
        mpp_o  <= PRIV_U;
      end else if (mpp_wr_i) begin
        mpp_o <= mpp_d_i;
      end
      if (cext_we_i) cext_o <= cext_d_i;
    end
  end
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CLEN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic            trap_req_i,
  input  logic [3:0]      trap_code_i,
  input  logic            tval_valid_i,
  input  logic [XLEN-1:0] tval_i,
  input  logic            cchk_i,
  input  logic [CLEN-1:0] cbits_i,
  input  logic            mret_req_i,
  input  logic            cext_we_i,
  input  logic            cext_d_i,
  input  logic            mpp_we_i,
  input  logic [1:0]      mpp_d_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mtval_o,
  output logic            mie_o,
  output logic            mpie_o,
  output logic [1:0]      mpp_o,
  output logic [1:0]      priv_o,
  output logic            cext_o,
  output logic            err_o
);
  localparam int ALIGN = 2;

  logic            attempt_w, take_w, bad_w;
  logic [3:0]      cause_w;
  logic [XLEN-1:0] tval_w;
  logic            ret_try, ret_w, ret_bad, mpp_wr;
  logic [XLEN-1:0] base_w;

  mtrap_cause #(.XLEN(XLEN), .CLEN(CLEN)) u_cause (
    .priv_i(priv_o), .trap_req_i(trap_req_i), .code_i(trap_code_i),
    .tval_valid_i(tval_valid_i), .tval_i(tval_i), .cchk_i(cchk_i),
    .cbits_i(cbits_i), .cext_i(cext_o), .attempt_o(attempt_w),
    .take_o(take_w), .bad_o(bad_w), .cause_o(cause_w), .tval_o(tval_w)
  );

  assign ret_try = mret_req_i && !attempt_w;
  assign ret_bad = ret_try && (mpp_o == PRIV_RSV);
  assign ret_w   = ret_try && !ret_bad;
  assign mpp_wr  = mpp_we_i && !attempt_w && !mret_req_i;
  assign base_w  = {mtvec_i[XLEN-1:ALIGN], {ALIGN{1'b0}}};

  mtrap_status u_status (
    .clk(clk), .rst(rst), .take_i(take_w), .ret_i(ret_w),
    .mpp_wr_i(mpp_wr), .mpp_d_i(mpp_d_i), .cext_we_i(cext_we_i),
    .cext_d_i(cext_d_i), .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o),
    .priv_o(priv_o), .cext_o(cext_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mepc_o     <= '0;
      mcause_o   <= '0;
      mtval_o    <= '0;
      next_pc_o  <= '0;
      redirect_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      redirect_o <= take_w || ret_w;
      err_o      <= bad_w || ret_bad;
      if (take_w) begin
        mepc_o    <= pc_i;
        mcause_o  <= XLEN'(cause_w);
        mtval_o   <= tval_w;
        next_pc_o <= base_w;
      end else if (ret_w) begin
        next_pc_o <= mepc_o;
      end
    end
  end
endmodule

// File: rtl/mtrap_unit_chk.sv
module mtrap_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            take,
  input logic            ret,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] mepc_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            redirect_o,
  input logic            err_o,
  input logic            mie_o,
  input logic            mpie_o,
  input logic [1:0]      mpp_o,
  input logic [1:0]      priv_o
);
  // R2
  trap_saves_pc_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (mepc_o == $past(pc_i)) && redirect_o);
  // R3
  trap_status_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (priv_o == 2'b11) && !mie_o && (mpie_o == $past(mie_o)) && (mpp_o == $past(priv_o)));
  // R10
  ret_restore_chk: assert property (@(posedge clk) disable iff (rst)
    ret |=> mpie_o && (mpp_o == 2'b00) && (priv_o == $past(mpp_o)) && (next_pc_o == $past(mepc_o)));
  // R6
  err_no_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !redirect_o);
  // R7
  err_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $stable(mepc_o) && $stable(priv_o) && $stable(mie_o) && $stable(mpp_o));
  // R11
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take, ret}));
endmodule

bind mtrap_unit mtrap_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .take(take_w), .ret(ret_w), .pc_i(pc_i),
  .mepc_o(mepc_o), .next_pc_o(next_pc_o), .redirect_o(redirect_o),
  .err_o(err_o), .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o),
  .priv_o(priv_o)
);

// File: tb/mtrap_unit_test.sv
`timescale 1ns/1ps
module mtrap_unit_test;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst;
  logic [XLEN-1:0] pc, mtvec, tval;
  logic trap_req, tval_valid, cchk, mret, cext_we, cext_d, mpp_we;
  logic [3:0] code;
  logic [15:0] cbits;
  logic [1:0] mpp_d;
  logic redirect, mie, mpie, cext, err;
  logic [XLEN-1:0] npc, mepc, mcause, mtval;
  logic [1:0] mpp, priv;

  int vectors = 0;
  int miscompares = 0;

  // reference state
  logic [1:0] r_priv, r_mpp;
  logic r_mie, r_mpie, r_cext, r_redir, r_err;
  logic [XLEN-1:0] r_mepc, r_mcause, r_mtval, r_npc;

  always #2.5 clk = ~clk;

  mtrap_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .pc_i(pc), .mtvec_i(mtvec), .trap_req_i(trap_req),
    .trap_code_i(code), .tval_valid_i(tval_valid), .tval_i(tval),
    .cchk_i(cchk), .cbits_i(cbits), .mret_req_i(mret), .cext_we_i(cext_we),
    .cext_d_i(cext_d), .mpp_we_i(mpp_we), .mpp_d_i(mpp_d),
    .redirect_o(redirect), .next_pc_o(npc), .mepc_o(mepc), .mcause_o(mcause),
    .mtval_o(mtval), .mie_o(mie), .mpie_o(mpie), .mpp_o(mpp), .priv_o(priv),
    .cext_o(cext), .err_o(err)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    trap_req = 0; code = 0; tval_valid = 0; tval = 0; cchk = 0; cbits = 0;
    mret = 0; cext_we = 0; cext_d = 0; mpp_we = 0; mpp_d = 0;
  endtask

  task automatic compare_all(input string tag);
    cmp(tag, "redirect", XLEN'(redirect), XLEN'(r_redir));
    cmp(tag, "err", XLEN'(err), XLEN'(r_err));
    cmp(tag, "next_pc", npc, r_npc);
    cmp(tag, "mepc", mepc, r_mepc);
    cmp(tag, "mcause", mcause, r_mcause);
    cmp(tag, "mtval", mtval, r_mtval);
    cmp(tag, "mie", XLEN'(mie), XLEN'(r_mie));
    cmp(tag, "mpie", XLEN'(mpie), XLEN'(r_mpie));
    cmp(tag, "mpp", XLEN'(mpp), XLEN'(r_mpp));
    cmp(tag, "priv", XLEN'(priv), XLEN'(r_priv));
    cmp(tag, "cext", XLEN'(cext), XLEN'(r_cext));
  endtask

  // model one edge from the requirements, then compare after it
  task automatic tick(input string tag);
    int c;
    logic ok, cill;
    logic [3:0] cs;
    logic [XLEN-1:0] tv;
    ok = 0; cs = 0; tv = 0;
    r_redir = 0; r_err = 0;
    c = int'(code);
    cill = cchk && !r_cext;
    if (trap_req) begin
      if (c == 8 || c == 9 || c == 11) begin
        ok = 1;
        cs = (r_priv == 2'b00) ? 4'd8 : (r_priv == 2'b01) ? 4'd9 : 4'd11;
      end else if (c == 3 || c == 10 || c == 14) r_err = 1;
      else if (!tval_valid) r_err = 1;
      else begin ok = 1; cs = code; tv = tval; end
    end else if (cill) begin
      ok = 1; cs = 4'd2; tv = XLEN'(cbits);
    end else if (mret) begin
      if (r_mpp == 2'b10) r_err = 1;
      else begin
        r_redir = 1; r_npc = r_mepc;
        r_mie = r_mpie; r_mpie = 1; r_priv = r_mpp; r_mpp = 2'b00;
      end
    end else if (mpp_we) r_mpp = mpp_d;
    if (ok) begin
      r_redir = 1; r_mepc = pc; r_mcause = XLEN'(cs); r_mtval = tv;
      r_npc = mtvec & ~XLEN'(3);
      r_mpie = r_mie; r_mie = 0; r_mpp = r_priv; r_priv = 2'b11;
    end
    if (cext_we) r_cext = cext_d;
    @(posedge clk); #1;
    compare_all(tag);
    idle();
  endtask

  task automatic trap(input logic [3:0] k, input logic v, input logic [XLEN-1:0] t,
                      input logic [XLEN-1:0] p, input string tag);
    trap_req = 1; code = k; tval_valid = v; tval = t; pc = p;
    tick(tag);
  endtask

  initial begin
    #150000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(); pc = 32'h100; mtvec = 32'h8000_0003; rst = 1;
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
    r_priv = 2'b11; r_mpp = 0; r_mie = 0; r_mpie = 0; r_cext = 1;
    r_redir = 0; r_err = 0; r_mepc = 0; r_mcause = 0; r_mtval = 0; r_npc = 0;
    compare_all("R1");
    tick("R1");
    // R2 R5: illegal instruction with a value
    trap(4'd2, 1, 32'hDEAD_BEEF, 32'h0000_0100, "R2");
    tick("R2");
    // R10: return with saved Machine, then with saved User
    mret = 1; tick("R10");
    mret = 1; tick("R10");
    // R4: call from User, code given as 11
    trap(4'd11, 0, 32'h55, 32'h204, "R4");
    // R12: write saved privilege to Supervisor, return, call from Supervisor
    mpp_we = 1; mpp_d = 2'b01; tick("R12");
    mret = 1; tick("R3");
    trap(4'd8, 1, 32'h77, 32'h308, "R4");
    trap(4'd9, 0, 0, 32'h30C, "R4");
    // R5: every value-carrying code
    for (int i = 0; i < 16; i++) begin
      if (!(i == 3 || i == 8 || i == 9 || i == 10 || i == 11 || i == 14))
        trap(4'(i), 1, 32'h1000 + i, 32'h400 + 4 * i, "R5");
    end
    // R6: missing value
    trap(4'd5, 0, 32'h9, 32'h500, "R6");
    trap(4'd13, 0, 32'h9, 32'h504, "R6");
    // R7: breakpoint and reserved
    trap(4'd3, 1, 32'h1, 32'h600, "R7");
    trap(4'd10, 1, 32'h1, 32'h604, "R7");
    trap(4'd14, 1, 32'h1, 32'h608, "R7");
    // R8: check with bit set is ignored
    cchk = 1; cbits = 16'hA5A5; pc = 32'h700; tick("R8");
    // R9: clear bit while a check is present; old value used
    cext_we = 1; cext_d = 0; cchk = 1; cbits = 16'h1111; tick("R9");
    cchk = 1; cbits = 16'hF00D; pc = 32'h704; tick("R8");
    // R11: trap beats compressed check and MRET
    trap_req = 1; code = 4'd4; tval_valid = 1; tval = 32'h44; cchk = 1;
    cbits = 16'h2222; mret = 1; pc = 32'h800; tick("R11");
    // R11: compressed check beats MRET
    cchk = 1; cbits = 16'h3333; mret = 1; pc = 32'h804; tick("R11");
    // R11: saved-privilege write ignored under MRET
    mpp_we = 1; mpp_d = 2'b01; mret = 1; tick("R11");
    // R12: write 10 then return gives an error
    mpp_we = 1; mpp_d = 2'b10; tick("R12");
    mret = 1; tick("R12");
    mpp_we = 1; mpp_d = 2'b11; trap_req = 1; code = 4'd11; pc = 32'h900; tick("R12");
    // R9: set bit back; check ignored again
    cext_we = 1; cext_d = 1; tick("R9");
    cchk = 1; cbits = 16'h4444; tick("R8");
    // R1: reset mid-run
    rst = 1; @(posedge clk); #1; rst = 0;
    r_priv = 2'b11; r_mpp = 0; r_mie = 0; r_mpie = 0; r_cext = 1;
    r_redir = 0; r_err = 0; r_mepc = 0; r_mcause = 0; r_mtval = 0; r_npc = 0;
    compare_all("R1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule